// File: doc/BRIEF.md
# Run-Time Routed Byte Stream Crossbar

This block links a set of stream plug-ins through a byte-wide switch whose routing is chosen at run time. Every plug-in has a byte output (producer side) and a byte input (consumer side). For every consumer, a select field in a routing register names the producer that feeds it. A data stream can therefore pass through any ordered chain of processing stages. The stream moves one byte per transfer under a valid/ready handshake, so any stage can stall the chain.

Two plug-ins are built into the block. A source streams a computed byte sequence from a start address for a programmed length. A sink takes exactly a programmed number of bytes and keeps a running sum of them. Other stages attach through external producer/consumer lanes. A controller drives everything through a 32-bit register port that is separate from the data path. The usual sequence is: set the routing, program and start the sink, then program and start the source, then poll the done bits. Later commands that use the same routing only restart the plug-ins.

Plug-in index map: 0 = source, 1 = sink, 2.. = external lanes 0.. in order. Register word addresses: 0 routing, 1 status, 2 source address, 3 source length, 4 source control, 5 sink address, 6 sink length, 7 sink control, 8 sink sum. Control register write: bit0=1 starts, bit1=1 (with bit0=0) stops. Control register read: bit0 busy, bit1 done.

Top module: `stream_xbar`

## Requirements
- R1: After reset, the routing register, status, and both control registers read 0. No external consumer lane shows valid, and every external producer lane sees ready high.
- R2: Consumer c takes its select field from routing bits [c*3+2:c*3] (default size). Code k in 1..4 connects producer k-1. That producer's data and valid reach consumer c in the same cycle, and consumer c's ready returns to that producer in the same cycle.
- R3: A consumer with select code 0 sees valid low. A producer that no consumer selects sees ready high.
- R4: A routing write made while the source or the sink is busy leaves the routing unchanged and sets status bit0. Status bit0 stays set until a 1 is written to status bit0.
- R5: A routing write that selects the same nonzero producer for two consumers, or that uses a code above 4, leaves the routing unchanged and sets status bit0.
- R6: Once started, the source offers LEN bytes. Byte i equals b[7:0] XOR b[15:8], where b = start address + i. Each byte is sent in order, one per cycle, and only when ready is high.
- R7: While the source is stalled, it keeps valid high and its byte unchanged.
- R8: The sink accepts exactly its programmed count, then drops ready. Sink sum (register 8) is the 16-bit wrapping sum of the accepted bytes.
- R9: When a plug-in finishes its count, done goes to 1 and busy goes to 0. A start clears done. A length of 0 finishes with no transfer.
- R10: The routing is kept across commands, so a second stream with different plug-in settings runs without the routing being rewritten.
- R11: A stop clears busy and leaves done at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_we_i | input | 1 | Register write strobe |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| ext_in_data_i | input | 16 | Bytes from external stage outputs, lane n at [8n+7:8n] |
| ext_in_valid_i | input | 2 | Valid from external stage outputs |
| ext_in_ready_o | output | 2 | Ready back to external stage outputs |
| ext_out_data_o | output | 16 | Bytes to external stage inputs |
| ext_out_valid_o | output | 2 | Valid to external stage inputs |
| ext_out_ready_i | input | 2 | Ready from external stage inputs |

## Verification
A bad select decode shows in the same cycle as a byte or valid on the wrong external lane, or as a ready returned to the wrong producer. A count off by one inside a plug-in shows as one byte too many or too few on the lane, as a wrong sink sum, or as done rising one transfer early or late. All of these are visible within one command. A routing register that takes a write it should reject is caught by the next read of that register, and a lost error flag by the next status read. A source that changes its byte under backpressure is caught by a byte comparison on the next accepted transfer.

// File: rtl/stream_xbar_pkg.sv
package stream_xbar_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned SUM_W   = 16;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned PORT_SRC = 0;
  localparam int unsigned PORT_SNK = 1;
  localparam int unsigned PORT_EXT = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_ROUTE    = 4'd0,
    REG_STAT     = 4'd1,
    REG_SRC_ADDR = 4'd2,
    REG_SRC_LEN  = 4'd3,
    REG_SRC_CTRL = 4'd4,
    REG_SNK_ADDR = 4'd5,
    REG_SNK_LEN  = 4'd6,
    REG_SNK_CTRL = 4'd7,
    REG_SNK_SUM  = 4'd8
  } reg_e;

  function automatic logic [BYTE_W-1:0] gen_byte(logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8];
  endfunction
endpackage

// File: rtl/stream_xbar_route.sv
module stream_xbar_route #(
  parameter int unsigned P     = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic [P*SEL_W-1:0] cfg_i,
  input  logic [P*8-1:0]     prod_data_i,
  input  logic [P-1:0]       prod_valid_i,
  output logic [P-1:0]       prod_ready_o,
  output logic [P*8-1:0]     cons_data_o,
  output logic [P-1:0]       cons_valid_o,
  input  logic [P-1:0]       cons_ready_i
);
  // codes are unique per producer (enforced on write), so no fan-out merge
  always_comb begin
    logic [SEL_W-1:0] sel;
    prod_ready_o = '1;
    cons_data_o  = '0;
    cons_valid_o = '0;
    for (int c = 0; c < int'(P); c++) begin
      sel = cfg_i[c*SEL_W +: SEL_W];
      for (int p = 0; p < int'(P); p++) begin
        if (sel == SEL_W'(p + 1)) begin
          cons_valid_o[c]       = prod_valid_i[p];
          cons_data_o[c*8 +: 8] = prod_data_i[p*8 +: 8];
          prod_ready_o[p]       = cons_ready_i[c];
        end
      end
    end
  end
endmodule

// File: rtl/stream_xbar_xfer.sv
module stream_xbar_xfer #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fire_i,
  output logic             active_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic             busy_q, done_q;
  logic [LEN_W-1:0] len_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      len_q  <= len_i;
      cnt_q  <= '0;
    end else if (stop_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == len_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (fire_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = busy_q && (cnt_q != len_q);
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/stream_xbar_src.sv
module stream_xbar_src
  import stream_xbar_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  cnt;
  logic              active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_q <= '0;
    else if (start_i) base_q <= addr_i;
  end

  stream_xbar_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk_i, .rst_ni, .start_i, .stop_i, .len_i,
    .fire_i  (active && ready_i),
    .active_o(active),
    .busy_o,
    .done_o,
    .cnt_o   (cnt)
  );

  assign valid_o = active;
  assign data_o  = gen_byte(base_q + ADDR_W'(cnt));
endmodule

// File: rtl/stream_xbar_snk.sv
module stream_xbar_snk
  import stream_xbar_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] sum_q;
  logic [LEN_W-1:0] unused_cnt;
  logic             active, fire;

  assign fire = active && valid_i;

  stream_xbar_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk_i, .rst_ni, .start_i, .stop_i, .len_i,
    .fire_i  (fire),
    .active_o(active),
    .busy_o,
    .done_o,
    .cnt_o   (unused_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (start_i) sum_q <= '0;
    else if (fire)    sum_q <= sum_q + SUM_W'(data_i);
  end

  assign ready_o = active;
  assign sum_o   = sum_q;
endmodule

// File: rtl/stream_xbar_regs.sv
module stream_xbar_regs
  import stream_xbar_pkg::*;
#(
  parameter int unsigned P     = 4,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_we_i,
  output logic [31:0]       bus_rdata_o,
  output logic [P*SEL_W-1:0] cfg_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [LEN_W-1:0]  src_len_o,
  output logic              src_start_o,
  output logic              src_stop_o,
  output logic [LEN_W-1:0]  snk_len_o,
  output logic              snk_start_o,
  output logic              snk_stop_o,
  input  logic              src_busy_i,
  input  logic              src_done_i,
  input  logic              snk_busy_i,
  input  logic              snk_done_i,
  input  logic [SUM_W-1:0]  snk_sum_i
);
  localparam int unsigned CFG_W = P * SEL_W;

  logic [CFG_W-1:0]  cfg_q, wr_cfg;
  logic              err_q, cfg_ok, cfg_wr, busy_any;
  logic [ADDR_W-1:0] src_addr_q, snk_addr_q;
  logic [LEN_W-1:0]  src_len_q, snk_len_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i;
  assign wr_cfg       = bus_wdata_i[CFG_W-1:0];
  assign busy_any     = src_busy_i | snk_busy_i;
  assign cfg_wr       = bus_we_i && (bus_addr_i == REG_ROUTE);

  always_comb begin
    cfg_ok = 1'b1;
    for (int c = 0; c < int'(P); c++) begin
      if (int'(wr_cfg[c*SEL_W +: SEL_W]) > int'(P)) cfg_ok = 1'b0;
      for (int d = c + 1; d < int'(P); d++) begin
        if (wr_cfg[c*SEL_W +: SEL_W] != '0 &&
            wr_cfg[c*SEL_W +: SEL_W] == wr_cfg[d*SEL_W +: SEL_W]) cfg_ok = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      err_q      <= 1'b0;
      src_addr_q <= '0;
      src_len_q  <= '0;
      snk_addr_q <= '0;
      snk_len_q  <= '0;
    end else if (bus_we_i) begin
      unique case (bus_addr_i)
        REG_ROUTE: begin
          if (busy_any || !cfg_ok) err_q <= 1'b1;
          else                     cfg_q <= wr_cfg;
        end
        REG_STAT:     if (bus_wdata_i[0]) err_q <= 1'b0;
        REG_SRC_ADDR: src_addr_q <= bus_wdata_i[ADDR_W-1:0];
        REG_SRC_LEN:  src_len_q  <= bus_wdata_i[LEN_W-1:0];
        REG_SNK_ADDR: snk_addr_q <= bus_wdata_i[ADDR_W-1:0];
        REG_SNK_LEN:  snk_len_q  <= bus_wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign src_start_o = bus_we_i && (bus_addr_i == REG_SRC_CTRL) && bus_wdata_i[0];
  assign src_stop_o  = bus_we_i && (bus_addr_i == REG_SRC_CTRL) && !bus_wdata_i[0] && bus_wdata_i[1];
  assign snk_start_o = bus_we_i && (bus_addr_i == REG_SNK_CTRL) && bus_wdata_i[0];
  assign snk_stop_o  = bus_we_i && (bus_addr_i == REG_SNK_CTRL) && !bus_wdata_i[0] && bus_wdata_i[1];

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_ROUTE:    bus_rdata_o = 32'(cfg_q);
      REG_STAT:     bus_rdata_o = {31'd0, err_q};
      REG_SRC_ADDR: bus_rdata_o = 32'(src_addr_q);
      REG_SRC_LEN:  bus_rdata_o = 32'(src_len_q);
      REG_SRC_CTRL: bus_rdata_o = {30'd0, src_done_i, src_busy_i};
      REG_SNK_ADDR: bus_rdata_o = 32'(snk_addr_q);
      REG_SNK_LEN:  bus_rdata_o = 32'(snk_len_q);
      REG_SNK_CTRL: bus_rdata_o = {30'd0, snk_done_i, snk_busy_i};
      REG_SNK_SUM:  bus_rdata_o = 32'(snk_sum_i);
      default:      bus_rdata_o = '0;
    endcase
  end

  assign cfg_o      = cfg_q;
  assign err_o      = err_q;
  assign src_addr_o = src_addr_q;
  assign src_len_o  = src_len_q;
  assign snk_len_o  = snk_len_q;
endmodule

// File: rtl/stream_xbar.sv
module stream_xbar
  import stream_xbar_pkg::*;
#(
  parameter int unsigned NUM_EXT = 2,
  parameter int unsigned LEN_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_AW-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  input  logic                  bus_we_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [NUM_EXT*8-1:0]  ext_in_data_i,
  input  logic [NUM_EXT-1:0]    ext_in_valid_i,
  output logic [NUM_EXT-1:0]    ext_in_ready_o,
  output logic [NUM_EXT*8-1:0]  ext_out_data_o,
  output logic [NUM_EXT-1:0]    ext_out_valid_o,
  input  logic [NUM_EXT-1:0]    ext_out_ready_i
);
  localparam int unsigned P     = NUM_EXT + PORT_EXT;
  localparam int unsigned SEL_W = $clog2(P + 1);
  localparam int unsigned CFG_W = P * SEL_W;

  logic [CFG_W-1:0]  cfg;
  logic [31:0]       cfg_word;
  logic              err;
  logic [P*8-1:0]    prod_data, cons_data;
  logic [P-1:0]      prod_valid, prod_ready, cons_valid, cons_ready;
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  src_len, snk_len;
  logic              src_start, src_stop, snk_start, snk_stop;
  logic              src_busy, src_done, snk_busy, snk_done;
  logic              src_valid, snk_ready;
  logic [7:0]        src_data;
  logic [SUM_W-1:0]  snk_sum;
  logic              any_busy;
  logic              unused_bits;

  assign any_busy = src_busy | snk_busy;
  assign cfg_word = 32'(cfg);

  stream_xbar_regs #(.P(P), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wdata_i, .bus_we_i, .bus_rdata_o,
    .cfg_o       (cfg),
    .err_o       (err),
    .src_addr_o  (src_addr),
    .src_len_o   (src_len),
    .src_start_o (src_start),
    .src_stop_o  (src_stop),
    .snk_len_o   (snk_len),
    .snk_start_o (snk_start),
    .snk_stop_o  (snk_stop),
    .src_busy_i  (src_busy),
    .src_done_i  (src_done),
    .snk_busy_i  (snk_busy),
    .snk_done_i  (snk_done),
    .snk_sum_i   (snk_sum)
  );

  stream_xbar_src #(.LEN_W(LEN_W)) u_src (
    .clk_i, .rst_ni,
    .start_i (src_start),
    .stop_i  (src_stop),
    .addr_i  (src_addr),
    .len_i   (src_len),
    .data_o  (src_data),
    .valid_o (src_valid),
    .ready_i (prod_ready[PORT_SRC]),
    .busy_o  (src_busy),
    .done_o  (src_done)
  );

  stream_xbar_snk #(.LEN_W(LEN_W)) u_snk (
    .clk_i, .rst_ni,
    .start_i (snk_start),
    .stop_i  (snk_stop),
    .len_i   (snk_len),
    .data_i  (cons_data[PORT_SNK*8 +: 8]),
    .valid_i (cons_valid[PORT_SNK]),
    .ready_o (snk_ready),
    .busy_o  (snk_busy),
    .done_o  (snk_done),
    .sum_o   (snk_sum)
  );

  // source has no input lane, sink has no output lane
  assign prod_data  = {ext_in_data_i, 8'h00, src_data};
  assign prod_valid = {ext_in_valid_i, 1'b0, src_valid};
  assign cons_ready = {ext_out_ready_i, snk_ready, 1'b1};

  stream_xbar_route #(.P(P), .SEL_W(SEL_W)) u_route (
    .cfg_i        (cfg),
    .prod_data_i  (prod_data),
    .prod_valid_i (prod_valid),
    .prod_ready_o (prod_ready),
    .cons_data_o  (cons_data),
    .cons_valid_o (cons_valid),
    .cons_ready_i (cons_ready)
  );

  assign ext_in_ready_o  = prod_ready[P-1:PORT_EXT];
  assign ext_out_data_o  = cons_data[P*8-1:PORT_EXT*8];
  assign ext_out_valid_o = cons_valid[P-1:PORT_EXT];
  assign unused_bits     = ^{prod_ready[PORT_SNK], cons_data[7:0], cons_valid[PORT_SRC], err};
endmodule

// File: rtl/stream_xbar_chk.sv
module stream_xbar_chk
  import stream_xbar_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [31:0]       cfg_word,
  input logic              err,
  input logic              any_busy,
  input logic              src_valid,
  input logic              src_ready,
  input logic [7:0]        src_data,
  input logic              src_start,
  input logic              src_stop,
  input logic              src_busy,
  input logic              src_done,
  input logic              snk_busy,
  input logic              snk_done
);
  p_route_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_busy |=> $stable(cfg_word));

  p_route_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_ROUTE && any_busy) |=> err);

  p_src_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid && !src_ready && !src_start && !src_stop) |=> (src_valid && $stable(src_data)));

  p_src_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_done |-> !src_busy);

  p_snk_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_done |-> !snk_busy);

  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_start |=> (src_busy && !src_done));

  p_stop_no_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_stop && !src_start) |=> !src_busy);
endmodule

bind stream_xbar stream_xbar_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .cfg_word   (cfg_word),
  .err        (err),
  .any_busy   (any_busy),
  .src_valid  (src_valid),
  .src_ready  (prod_ready[0]),
  .src_data   (src_data),
  .src_start  (src_start),
  .src_stop   (src_stop),
  .src_busy   (src_busy),
  .src_done   (src_done),
  .snk_busy   (snk_busy),
  .snk_done   (snk_done)
);

// File: tb/stream_xbar_tb.sv
module stream_xbar_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] ext_in_data = '0;
  logic [1:0]  ext_in_valid = '0;
  logic [1:0]  ext_in_ready;
  logic [15:0] ext_out_data;
  logic [1:0]  ext_out_valid;
  logic [1:0]  ext_out_ready = '0;

  int n_chk = 0, n_bad = 0;
  bit lb_on = 1'b0, acc_prev = 1'b0;
  int lb_pct = 60;
  int rx_n = 0;
  logic [15:0] rx_base = '0;
  logic [7:0] lb_q[$];

  always #5 clk = ~clk;

  stream_xbar u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_we_i(bus_we), .bus_rdata_o(bus_rdata),
    .ext_in_data_i(ext_in_data), .ext_in_valid_i(ext_in_valid), .ext_in_ready_o(ext_in_ready),
    .ext_out_data_o(ext_out_data), .ext_out_valid_o(ext_out_valid), .ext_out_ready_i(ext_out_ready)
  );

  function automatic logic [7:0] exp_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  function automatic logic [15:0] exp_sum(logic [15:0] a, int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + 16'(exp_byte(a + 16'(i)));
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // external stage on lane 0: takes bytes from ext_out[0], returns them on ext_in[0]
  initial begin
    forever begin
      @(negedge clk);
      if (lb_on) begin
        if (acc_prev) void'(lb_q.pop_front());
        ext_out_ready[0] = ($urandom % 100) < lb_pct;
        ext_in_valid[0]  = (lb_q.size() > 0) && (($urandom % 100) < lb_pct);
        ext_in_data[7:0] = (lb_q.size() > 0) ? lb_q[0] : 8'h00;
        #1;
        if (ext_out_valid[0] && ext_out_ready[0]) begin
          chk($sformatf("R6 byte %0d", rx_n), 32'(ext_out_data[7:0]), 32'(exp_byte(rx_base + 16'(rx_n))));
          lb_q.push_back(ext_out_data[7:0]);
          rx_n++;
        end
        acc_prev = ext_in_valid[0] && ext_in_ready[0];
      end else begin
        acc_prev = 1'b0;
      end
    end
  end

  task automatic run_stream(logic [15:0] a, int n, string tag);
    logic [31:0] d;
    wr(4'd6, 32'(n));
    wr(4'd7, 32'h1);
    rd(4'd7, d);
    chk({tag, " R9 start clears done"}, d, 32'h1);
    wr(4'd2, 32'(a));
    wr(4'd3, 32'(n));
    rx_n = 0; rx_base = a; lb_q.delete(); acc_prev = 1'b0;
    lb_on = 1'b1;
    wr(4'd4, 32'h1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(4'd7, d);
      if (d[1]) break;
    end
    lb_on = 1'b0;
    @(negedge clk);
    ext_out_ready = '0; ext_in_valid = '0;
    chk({tag, " R6 byte count"}, 32'(rx_n), 32'(n));
    rd(4'd7, d);  chk({tag, " R9 sink done"}, d, 32'h2);
    rd(4'd4, d);  chk({tag, " R9 source done"}, d, 32'h2);
    rd(4'd8, d);  chk({tag, " R8 sink sum"}, d, 32'(exp_sum(a, n)));
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0] b[5];
    int k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); chk("R1 route", d, 0);
    rd(4'd1, d); chk("R1 status", d, 0);
    rd(4'd4, d); chk("R1 src ctrl", d, 0);
    rd(4'd7, d); chk("R1 snk ctrl", d, 0);
    chk("R1 R3 idle lanes", {28'd0, ext_out_valid, ext_in_ready}, 32'h3);

    // R2 straight and crossed routing between external lanes
    wr(4'd0, (32'd3 << 6) | (32'd4 << 9));
    for (int i = 0; i < 10; i++) begin
      ext_in_data = 16'($urandom); ext_in_valid = 2'($urandom); ext_out_ready = 2'($urandom);
      #1;
      chk("R2 straight", {ext_out_data, 10'd0, ext_out_valid, ext_in_ready, ext_out_ready},
          {ext_in_data, 10'd0, ext_in_valid, ext_out_ready, ext_out_ready});
      @(negedge clk);
    end
    wr(4'd0, (32'd4 << 6) | (32'd3 << 9));
    for (int i = 0; i < 10; i++) begin
      ext_in_data = 16'($urandom); ext_in_valid = 2'($urandom); ext_out_ready = 2'($urandom);
      #1;
      chk("R2 crossed", {ext_out_data, 12'd0, ext_out_valid, ext_in_ready},
          {ext_in_data[7:0], ext_in_data[15:8], 12'd0, ext_in_valid[0], ext_in_valid[1],
           ext_out_ready[0], ext_out_ready[1]});
      @(negedge clk);
    end

    // R3 unconnected lanes
    wr(4'd0, 32'd3 << 6);
    for (int i = 0; i < 4; i++) begin
      ext_in_valid = 2'b11; ext_out_ready = 2'($urandom);
      #1;
      chk("R3 lane1 unrouted", {30'd0, ext_out_valid[1], ext_in_ready[1]}, 32'h1);
      @(negedge clk);
    end
    wr(4'd0, 32'd0);
    ext_in_valid = 2'b11; ext_out_ready = 2'b00;
    #1;
    chk("R3 all unrouted", {28'd0, ext_out_valid, ext_in_ready}, 32'h3);
    ext_in_valid = '0;

    // R5 illegal routing codes
    wr(4'd0, (32'd3 << 6) | (32'd4 << 9));
    wr(4'd0, (32'd3 << 6) | (32'd3 << 9));
    rd(4'd0, d); chk("R5 duplicate ignored", d, (32'd3 << 6) | (32'd4 << 9));
    rd(4'd1, d); chk("R5 duplicate flags", d, 1);
    wr(4'd1, 1);
    wr(4'd0, 32'd6);
    rd(4'd0, d); chk("R5 code>4 ignored", d, (32'd3 << 6) | (32'd4 << 9));
    rd(4'd1, d); chk("R5 code>4 flags", d, 1);
    wr(4'd1, 1);
    rd(4'd1, d); chk("R4 flag clear", d, 0);

    // R6 R8 R9 chain: source -> ext lane0 -> sink, random backpressure
    wr(4'd0, (32'd3 << 3) | (32'd1 << 6));
    lb_pct = 60;
    run_stream(16'h12F0, 37, "chain1");

    // R4 routing write while busy, R11 stop
    wr(4'd6, 5);
    wr(4'd7, 1);
    wr(4'd0, 32'd0);
    rd(4'd0, d); chk("R4 busy write ignored", d, (32'd3 << 3) | (32'd1 << 6));
    rd(4'd1, d); chk("R4 busy write flags", d, 1);
    rd(4'd7, d); chk("R11 busy before stop", d, 1);
    wr(4'd7, 2);
    rd(4'd7, d); chk("R11 stop no done", d, 0);
    wr(4'd0, (32'd3 << 3) | (32'd1 << 6));
    rd(4'd1, d); chk("R4 flag sticky", d, 1);
    wr(4'd1, 1);

    // R10 second command, routing not rewritten, heavier stalls
    lb_pct = 30;
    run_stream(16'hA07C, 20, "chain2");
    rd(4'd0, d); chk("R10 route kept", d, (32'd3 << 3) | (32'd1 << 6));

    // R9 zero length source
    wr(4'd0, 32'd1 << 6);
    wr(4'd3, 0);
    wr(4'd4, 1);
    ext_out_ready = 2'b01;
    #1;
    chk("R9 len0 no valid", 32'(ext_out_valid), 0);
    @(negedge clk);
    rd(4'd4, d); chk("R9 len0 done", d, 2);

    // R7 stall holds source byte
    ext_out_ready = 2'b00;
    wr(4'd2, 32'h0203);
    wr(4'd3, 4);
    wr(4'd4, 1);
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R7 stalled hold", {23'd0, ext_out_valid[0], ext_out_data[7:0]}, {23'd0, 1'b1, exp_byte(16'h0203)});
      @(negedge clk);
    end
    ext_out_ready = 2'b01;
    repeat (6) @(negedge clk);
    ext_out_ready = 2'b00;
    rd(4'd4, d); chk("R7 drain done", d, 2);

    // R8 sink takes exactly its count
    wr(4'd0, 32'd3 << 3);
    wr(4'd6, 3);
    wr(4'd7, 1);
    foreach (b[i]) b[i] = 8'($urandom);
    k = 0;
    for (int i = 0; i < 8; i++) begin
      ext_in_valid[0] = (k < 5);
      ext_in_data[7:0] = (k < 5) ? b[k] : 8'h00;
      #1;
      if (ext_in_valid[0] && ext_in_ready[0]) k++;
      @(negedge clk);
    end
    ext_in_valid = '0;
    chk("R8 accepted count", 32'(k), 3);
    #1;
    chk("R8 ready dropped", 32'(ext_in_ready[0]), 0);
    rd(4'd8, d); chk("R8 exact sum", d, 32'(16'(b[0]) + 16'(b[1]) + 16'(b[2])));
    rd(4'd7, d); chk("R9 sink exact done", d, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule